// File: doc/BRIEF.md
# Normalize and Round-to-Nearest-Even Unit

This block takes the raw sum or difference from a floating-point adder and turns it into a normalized, rounded significand with a matching exponent. The incoming significand is not normalized. Its most significant bit catches a carry out of an addition, the next bit is the integer bit, and the fraction bits follow. Three extra low-order bits sit below the fraction: guard, round and sticky, in that order from high to low. The exponent that arrives with it belongs to the unshifted value.

The unit first normalizes the value. A carry out moves it right by one place, and any bits lost from the low end are folded into the sticky bit. A result that lost its leading ones through cancellation moves left until the integer bit is set, with zeros shifted in from below. The rounding decision comes only after this shift, so after a left shift the old round and sticky bits stand in the guard and round places when the decision is made. The unit then rounds to the target width with round-to-nearest, ties-to-even. If rounding carries the significand up to the next power of two, the unit normalizes it once more.

The output can pass through an optional register stage with a clock enable. Alignment, the add or subtract itself, special values and the other rounding modes are handled elsewhere.

Top module: `nrm_round_unit`

## Requirements
- R1: While `rst_n` is low, `res_sig` and `res_exp` are zero.
- R2: An all-zero `raw_sig` produces `res_sig` = 0 and `res_exp` = 0, whatever `raw_exp` is.
- R3: When bit SIG_W+3 of `raw_sig` (the carry bit) is 1, the value is shifted right by one and the exponent is incremented. The two lowest input bits are ORed into the new sticky bit.
- R4: When the carry bit and the integer bit (bit SIG_W+2) are both 0 and the input is nonzero, the value is shifted left by the number of leading zeros below the carry bit, with zeros filled in at the bottom. The exponent is decreased by the same count.
- R5: After normalization, if the guard bit (the first bit below the kept LSB) is 0, the kept significand is passed through unchanged.
- R6: If the guard bit and the round bit are both 1, the significand is incremented.
- R7: If the guard bit is 1, the round bit is 0 and the sticky bit is 1, the significand is incremented.
- R8: If the guard, round and sticky bits are exactly 1, 0, 0, the significand is incremented only when its LSB is 1 (ties to even).
- R9: If rounding carries the significand out to 2.0, the result becomes 1.000…0 and the exponent is incremented once more.
- R10: A nonzero result always has the MSB of `res_sig` set.
- R11: With OUT_REG = 1, results appear one clock after the inputs while `en` is 1, and the outputs hold their value while `en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable of the output register |
| raw_sig | input | SIG_W+4 | Carry bit, integer bit, fraction, then guard/round/sticky |
| raw_exp | input | EXP_W | Exponent of the unnormalized input |
| res_sig | output | SIG_W | Normalized, rounded significand, integer bit at the MSB |
| res_exp | output | EXP_W | Adjusted exponent |

## Verification
The hardest cases to reach are the ones where normalization and rounding interact. One is a left shift that moves the old sticky bit up into the round place, so that it now decides a tie. The other is a carry-out input whose rounding then carries out a second time, which gives two exponent increments. With the default 4-bit significand the input is only 8 bits wide, so the bench sweeps every raw pattern under several exponents and reaches both situations on the way. Expected values come from exact integer rounding of the input at the bit position its leading one implies.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
  typedef enum logic [1:0] {
    RA_TRUNC = 2'd0,
    RA_UP    = 2'd1,
    RA_TIE   = 2'd2
  } round_act_t;
endpackage

// File: rtl/nrm_shift.sv
module nrm_shift #(
  parameter int SIG_W = 4,
  parameter int EXP_W = 8
) (
  input  logic [SIG_W+3:0] x_sig,
  input  logic [EXP_W-1:0] x_exp,
  output logic [SIG_W+2:0] n_sig,
  output logic [EXP_W-1:0] n_exp
);
  localparam int TOP = SIG_W + 3;
  localparam int LZW = $clog2(SIG_W + 4);

  logic [LZW-1:0] lz;
  logic           found;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = TOP - 1; i >= 0; i--) begin
      if (!found && x_sig[i]) begin
        lz    = LZW'(TOP - 1 - i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    if (x_sig == '0) begin
      n_sig = '0;
      n_exp = '0;
    end else if (x_sig[TOP]) begin
      n_sig = {x_sig[TOP:2], |x_sig[1:0]};
      n_exp = x_exp + EXP_W'(1);
    end else begin
      n_sig = x_sig[TOP-1:0] << lz;
      n_exp = x_exp - EXP_W'(lz);
    end
  end

  // R4 / R10: any nonzero input leaves the shifter with its integer bit set
  always_comb begin
    if (x_sig != '0) begin
      assert_norm_lead_R4: assert (n_sig[SIG_W+2]);
    end
  end
endmodule

// File: rtl/nrm_rne.sv
module nrm_rne #(
  parameter int SIG_W = 4,
  parameter int EXP_W = 8
) (
  input  logic [SIG_W+2:0] n_sig,
  input  logic [EXP_W-1:0] n_exp,
  output logic [SIG_W-1:0] r_sig,
  output logic [EXP_W-1:0] r_exp
);
  import nrm_pkg::*;

  logic [SIG_W-1:0] keep;
  logic             g_bit, r_bit, s_bit, inc;
  logic [SIG_W:0]   sum;
  round_act_t       act;

  assign keep  = n_sig[SIG_W+2:3];
  assign g_bit = n_sig[2];
  assign r_bit = n_sig[1];
  assign s_bit = n_sig[0];

  always_comb begin
    if (!g_bit)              act = RA_TRUNC;
    else if (r_bit || s_bit) act = RA_UP;
    else                     act = RA_TIE;
  end

  assign inc = (act == RA_UP) || ((act == RA_TIE) && keep[0]);
  assign sum = {1'b0, keep} + {{SIG_W{1'b0}}, inc};

  always_comb begin
    if (sum[SIG_W]) begin
      r_sig = sum[SIG_W:1];
      r_exp = n_exp + EXP_W'(1);
    end else begin
      r_sig = sum[SIG_W-1:0];
      r_exp = n_exp;
    end
  end

  // R5: a clear guard bit never alters the kept significand
  always_comb begin
    if (!g_bit) begin
      assert_trunc_keeps_R5: assert (r_sig == keep && r_exp == n_exp);
    end
  end
endmodule

// File: rtl/nrm_round_unit.sv
module nrm_round_unit #(
  parameter int SIG_W   = 4,
  parameter int EXP_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SIG_W+3:0] raw_sig,
  input  logic [EXP_W-1:0] raw_exp,
  output logic [SIG_W-1:0] res_sig,
  output logic [EXP_W-1:0] res_exp
);
  logic [SIG_W+2:0] n_sig;
  logic [EXP_W-1:0] n_exp;
  logic [SIG_W-1:0] c_sig;
  logic [EXP_W-1:0] c_exp;

  nrm_shift #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_shift (
    .x_sig(raw_sig), .x_exp(raw_exp), .n_sig(n_sig), .n_exp(n_exp)
  );

  nrm_rne #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_rne (
    .n_sig(n_sig), .n_exp(n_exp), .r_sig(c_sig), .r_exp(c_exp)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [SIG_W-1:0] sig_q, sig_d;
      logic [EXP_W-1:0] exp_q, exp_d;

      always_comb begin
        sig_d = sig_q;
        exp_d = exp_q;
        if (en) begin
          sig_d = c_sig;
          exp_d = c_exp;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sig_q <= '0;
          exp_q <= '0;
        end else begin
          sig_q <= sig_d;
          exp_q <= exp_d;
        end
      end

      assign res_sig = sig_q;
      assign res_exp = exp_q;

      assert_zero_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && raw_sig == '0) |=> (res_sig == '0 && res_exp == '0));
      assert_carry_exp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && raw_sig[SIG_W+3]) |=>
          (res_exp == $past(raw_exp) + EXP_W'(1) || res_exp == $past(raw_exp) + EXP_W'(2)));
      assert_lead_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_sig == '0) || res_sig[SIG_W-1]);
      assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(res_sig) && $stable(res_exp)));
    end else begin : g_comb
      assign res_sig = c_sig;
      assign res_exp = c_exp;
    end
  endgenerate
endmodule

// File: tb/test_nrm_round_unit.sv
module test_nrm_round_unit;
  localparam int SIG_W = 4;
  localparam int EXP_W = 8;
  localparam int IN_W  = SIG_W + 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [IN_W-1:0]  raw_sig = '0;
  logic [EXP_W-1:0] raw_exp = '0;
  logic [SIG_W-1:0] res_sig;
  logic [EXP_W-1:0] res_exp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nrm_round_unit #(.SIG_W(SIG_W), .EXP_W(EXP_W), .OUT_REG(1'b1)) i_nrm_round_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .raw_sig(raw_sig), .raw_exp(raw_exp),
    .res_sig(res_sig), .res_exp(res_exp)
  );

  task automatic check(input string req, input int a_sig, input int a_exp,
                       input int e_sig, input int e_exp);
    checks++;
    if (a_sig != e_sig || a_exp != e_exp) begin
      errors++;
      $display("FAIL %s raw=%02h exp=%02h: got sig=%0h exp=%02h, expected sig=%0h exp=%02h",
               req, raw_sig, raw_exp, a_sig, a_exp, e_sig, e_exp);
    end
  endtask

  // exact rounding of the input at the position its leading one implies
  task automatic reference(input int v, input int e, output int q, output int eo,
                           output string tag);
    int p, k, rem, half;
    bit carried;
    carried = 1'b0;
    if (v == 0) begin
      q = 0; eo = 0; tag = "R2"; return;
    end
    p = 0;
    for (int i = 0; i < IN_W; i++) if ((v >> i) & 1) p = i;
    k = p - (SIG_W - 1);
    if (k > 0) begin
      q = v >> k;
      rem = v & ((1 << k) - 1);
      half = 1 << (k - 1);
      if (rem > half || (rem == half && (q & 1) == 1)) q = q + 1;
    end else begin
      q = v << (-k);
    end
    eo = e + p - (SIG_W + 2);
    if (q == (1 << SIG_W)) begin
      q = q >> 1; eo = eo + 1; carried = 1'b1;
    end
    eo = eo & ((1 << EXP_W) - 1);
    if (carried)                 tag = "R9";
    else if (p == IN_W - 1)      tag = "R3";
    else if (p < IN_W - 2)       tag = "R4";
    else if (((v >> 2) & 1) == 0) tag = "R5";
    else if (((v >> 1) & 1) == 1) tag = "R6";
    else if ((v & 1) == 1)       tag = "R7";
    else                         tag = "R8";
  endtask

  initial begin
    int eq, ee;
    string tag;
    int exps[3] = '{8'h40, 8'h03, 8'hC7};
    repeat (3) @(negedge clk);
    check("R1", res_sig, res_exp, 0, 0);
    rst_n = 1'b1;
    en = 1'b1;
    foreach (exps[j]) begin
      for (int v = 0; v < (1 << IN_W); v++) begin
        @(negedge clk);
        raw_sig = IN_W'(v);
        raw_exp = EXP_W'(exps[j]);
        @(negedge clk);
        reference(v, exps[j], eq, ee, tag);
        check(tag, res_sig, res_exp, eq, ee);
        if (!res_sig[SIG_W-1] && res_sig != 0) check("R10", res_sig, 0, 8, 0);
      end
    end
    // R11: enable low freezes the outputs
    @(negedge clk);
    raw_sig = 8'h5A; raw_exp = 8'h20;
    @(negedge clk);
    reference(8'h5A, 8'h20, eq, ee, tag);
    check("R11", res_sig, res_exp, eq, ee);
    en = 1'b0;
    raw_sig = 8'h9F; raw_exp = 8'h11;
    repeat (2) @(negedge clk);
    check("R11", res_sig, res_exp, eq, ee);
    en = 1'b1;
    @(negedge clk);
    reference(8'h9F, 8'h11, eq, ee, tag);
    check("R11", res_sig, res_exp, eq, ee);
    // R1: asynchronous reset clears outputs again
    rst_n = 1'b0;
    #1;
    check("R1", res_sig, res_exp, 0, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule